// File: doc/BRIEF.md
# Banked Vectored Interrupt Controller

This block collects level interrupt requests from a parameterised number of sources (96 by default) and presents them to a processor as two lines. One is an ordinary interrupt line and the other is a fast interrupt line. The per-source state is kept in 32-bit banks: enable, mask, routing, IRQ pending, FIQ pending and a 2-bit priority field. Software reaches all of it through a single-cycle word-addressed register bus.

A request seen high at a clock edge latches a pending bit on the side its routing bit selects. A pending bit drives its output line only while its source is enabled and unmasked. Software acknowledges by reading a pending word, which returns the word and clears it in the same access. A vector word reports a programmable base plus four times the number of the most urgent IRQ-side source. A select/view pair lets software inspect all state of one source in a single read with no side effects.

Top module: `vic_bank_ctrl`

## Requirements
- R1: After reset every enable, routing, pending, base, select and priority bit is 0, every mask bit is 1, both `irq_o` and `fiq_o` are low, and the vector reads base + 4*NUM_SRC.
- R2: Word addresses: 0 vector (read-only), 1 base, 2 select, 3 view (read-only), 4+k IRQ pending, 8+k FIQ pending, 12+k routing, 16+k enable, 20+k mask, 24+p priority. Source n sits in bank word k = n/32 at bit n%32. Bank words at or beyond ceil(NUM_SRC/32) read as 0.
- R3: A request that is high at a clock edge sets the source's IRQ pending bit when its routing bit is 0, or its FIQ pending bit when the routing bit is 1. This happens whatever the enable and mask bits hold.
- R4: `irq_o` is a register that goes high one cycle after any source is IRQ-pending with enable = 1 and mask = 1'b0. A source with enable 0 or mask 1 never raises it. Unmasking a source that is already pending raises it with no new request.
- R5: `fiq_o` is formed the same way from FIQ pending bits, and FIQ-side activity never raises `irq_o`.
- R6: Reading a pending word returns its bits and clears that word at the same edge. Bus writes to pending words have no effect.
- R7: A request that is high at the edge of a clearing read of its word stays pending after the read.
- R8: The vector reads base + 4*winner, where the winner is taken among eligible IRQ-side sources. With no eligible source it reads base + 4*NUM_SRC. It follows pending and priority changes with one cycle of latency.
- R9: The winner has the highest priority value (3 is most urgent). Among equal priorities the lowest source number wins.
- R10: Priorities are 2-bit fields, 16 to a word. Source n uses priority word n/16 at bits 2*(n%16)+1:2*(n%16). Each priority word reads back as it was written.
- R11: The view word shows the selected source as {prio[6:5], FIQ pending[4], IRQ pending[3], routing[2], mask[1], enable[0]}. It reads 0 when the select value is NUM_SRC or above. Writing the select word and reading the view word change no pending state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| src_i | input | NUM_SRC | Level request per source |
| bus_req_i | input | 1 | Bus access this cycle |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 5 | Word address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, valid in the cycle of a read |
| irq_o | output | 1 | Registered interrupt line |
| fiq_o | output | 1 | Registered fast interrupt line |

## Verification
A new request can arrive in the very cycle in which software reads and clears the pending word that holds it. The bench provokes this by holding a source high across a pending-word read. It then reads the word twice more: the first of these must still show the bit and the second must show it gone. The other same-cycle pairings are a select write or view read coinciding with quiet sources, which must leave pending state untouched, and a priority write landing while several sources pend. For the priority case the vector is judged one cycle later against a winner computed in the bench from priority value and source number.

// File: rtl/vic_pkg.sv
package vic_pkg;
  localparam int unsigned WORD_W         = 32;
  localparam int unsigned PRIO_W         = 2;
  localparam int unsigned ADDR_W         = 5;
  localparam int unsigned MAX_BANK_WORDS = 4;
  localparam int unsigned MAX_PRIO_WORDS = 8;

  localparam logic [ADDR_W-1:0] A_VEC   = 5'd0;
  localparam logic [ADDR_W-1:0] A_BASE  = 5'd1;
  localparam logic [ADDR_W-1:0] A_SEL   = 5'd2;
  localparam logic [ADDR_W-1:0] A_VIEW  = 5'd3;
  localparam logic [ADDR_W-1:0] A_IPND  = 5'd4;
  localparam logic [ADDR_W-1:0] A_FPND  = 5'd8;
  localparam logic [ADDR_W-1:0] A_ROUTE = 5'd12;
  localparam logic [ADDR_W-1:0] A_EN    = 5'd16;
  localparam logic [ADDR_W-1:0] A_MASK  = 5'd20;
  localparam logic [ADDR_W-1:0] A_PRIO  = 5'd24;

  typedef enum logic [2:0] {
    BK_CTL     = 3'd0,
    BK_IPND    = 3'd1,
    BK_FPND    = 3'd2,
    BK_ROUTE   = 3'd3,
    BK_EN      = 3'd4,
    BK_MASK    = 3'd5,
    BK_PRIO_LO = 3'd6,
    BK_PRIO_HI = 3'd7
  } bank_e;

  typedef struct packed {
    logic [PRIO_W-1:0] prio;
    logic              fpnd;
    logic              ipnd;
    logic              route;
    logic              mask;
    logic              en;
  } view_t;
endpackage

// File: rtl/vic_pend_word.sv
module vic_pend_word #(
  parameter int unsigned W     = 32,
  parameter logic [W-1:0] VALID = '1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] src_i,
  input  logic [W-1:0] route_i,
  input  logic         clr_irq_i,
  input  logic         clr_fiq_i,
  output logic [W-1:0] irq_pend_o,
  output logic [W-1:0] fiq_pend_o
);
  logic [W-1:0] set_irq, set_fiq;

  assign set_irq = src_i & ~route_i & VALID;
  assign set_fiq = src_i &  route_i & VALID;

  // new requests win over a same-edge clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_pend_o <= '0;
      fiq_pend_o <= '0;
    end else begin
      irq_pend_o <= (clr_irq_i ? '0 : irq_pend_o) | set_irq;
      fiq_pend_o <= (clr_fiq_i ? '0 : fiq_pend_o) | set_fiq;
    end
  end
endmodule

// File: rtl/vic_prio_pick.sv
module vic_prio_pick #(
  parameter int unsigned N  = 96,
  parameter int unsigned PW = 2,
  parameter int unsigned IW = 7
) (
  input  logic [N-1:0]    elig_i,
  input  logic [N*PW-1:0] prio_i,
  output logic            valid_o,
  output logic [IW-1:0]   idx_o
);
  logic [PW-1:0] best;

  // scan downward with >= so the lowest index wins ties
  always_comb begin
    valid_o = 1'b0;
    idx_o   = '0;
    best    = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (elig_i[i] && (!valid_o || prio_i[i*PW +: PW] >= best)) begin
        valid_o = 1'b1;
        best    = prio_i[i*PW +: PW];
        idx_o   = IW'(i);
      end
    end
  end
endmodule

// File: rtl/vic_bank_ctrl.sv
module vic_bank_ctrl
  import vic_pkg::*;
#(
  parameter int unsigned NUM_SRC = 96
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_SRC-1:0]  src_i,
  input  logic                bus_req_i,
  input  logic                bus_we_i,
  input  logic [ADDR_W-1:0]   bus_addr_i,
  input  logic [WORD_W-1:0]   bus_wdata_i,
  output logic [WORD_W-1:0]   bus_rdata_o,
  output logic                irq_o,
  output logic                fiq_o
);
  localparam int unsigned NW     = (NUM_SRC + WORD_W - 1) / WORD_W;
  localparam int unsigned PAD    = NW * WORD_W;
  localparam int unsigned PPW    = WORD_W / PRIO_W;
  localparam int unsigned NPW    = (NUM_SRC + PPW - 1) / PPW;
  localparam int unsigned IDX_W  = $clog2(NUM_SRC + 1);

  logic                rd_en, wr_en;
  logic [PAD-1:0]      src_pad, en_q, mask_q, route_q;
  logic [PAD-1:0]      irq_pend, fiq_pend, irq_elig, fiq_elig;
  logic [NPW*WORD_W-1:0] prio_q;
  logic [WORD_W-1:0]   base_q, vector;
  logic [IDX_W-1:0]    sel_q, win_q, pick_idx;
  logic                pick_valid, irq_q, fiq_q;
  view_t               view;

  logic [MAX_BANK_WORDS-1:0][WORD_W-1:0] ipnd_w, fpnd_w, route_w, en_w, mask_w;
  logic [MAX_PRIO_WORDS-1:0][WORD_W-1:0] prio_w;

  assign rd_en = bus_req_i & ~bus_we_i;
  assign wr_en = bus_req_i &  bus_we_i;

  always_comb begin
    src_pad = '0;
    src_pad[NUM_SRC-1:0] = src_i;
  end

  for (genvar w = 0; w < NW; w++) begin : g_word
    localparam int unsigned LEFT = NUM_SRC - w * WORD_W;
    localparam int unsigned VC   = (LEFT > WORD_W) ? WORD_W : LEFT;
    localparam logic [WORD_W-1:0] VM =
      (VC == WORD_W) ? '1 : WORD_W'((64'd1 << VC) - 64'd1);

    vic_pend_word #(.W(WORD_W), .VALID(VM)) u_pend (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .src_i      (src_pad[w*WORD_W +: WORD_W]),
      .route_i    (route_q[w*WORD_W +: WORD_W]),
      .clr_irq_i  (rd_en && (bus_addr_i == A_IPND + ADDR_W'(w))),
      .clr_fiq_i  (rd_en && (bus_addr_i == A_FPND + ADDR_W'(w))),
      .irq_pend_o (irq_pend[w*WORD_W +: WORD_W]),
      .fiq_pend_o (fiq_pend[w*WORD_W +: WORD_W])
    );

    assign ipnd_w[w]  = irq_pend[w*WORD_W +: WORD_W];
    assign fpnd_w[w]  = fiq_pend[w*WORD_W +: WORD_W];
    assign route_w[w] = route_q[w*WORD_W +: WORD_W];
    assign en_w[w]    = en_q[w*WORD_W +: WORD_W];
    assign mask_w[w]  = mask_q[w*WORD_W +: WORD_W];
  end

  for (genvar w = NW; w < MAX_BANK_WORDS; w++) begin : g_word_pad
    assign ipnd_w[w]  = '0;
    assign fpnd_w[w]  = '0;
    assign route_w[w] = '0;
    assign en_w[w]    = '0;
    assign mask_w[w]  = '0;
  end

  for (genvar p = 0; p < NPW; p++) begin : g_prio
    assign prio_w[p] = prio_q[p*WORD_W +: WORD_W];
  end
  for (genvar p = NPW; p < MAX_PRIO_WORDS; p++) begin : g_prio_pad
    assign prio_w[p] = '0;
  end

  // configuration registers
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q    <= '0;
      mask_q  <= '1;
      route_q <= '0;
      prio_q  <= '0;
      base_q  <= '0;
      sel_q   <= '0;
    end else if (wr_en) begin
      if (bus_addr_i == A_BASE) base_q <= bus_wdata_i;
      if (bus_addr_i == A_SEL)  sel_q  <= bus_wdata_i[IDX_W-1:0];
      for (int w = 0; w < NW; w++) begin
        if (bus_addr_i == A_EN + ADDR_W'(w))    en_q[w*WORD_W +: WORD_W]    <= bus_wdata_i;
        if (bus_addr_i == A_MASK + ADDR_W'(w))  mask_q[w*WORD_W +: WORD_W]  <= bus_wdata_i;
        if (bus_addr_i == A_ROUTE + ADDR_W'(w)) route_q[w*WORD_W +: WORD_W] <= bus_wdata_i;
      end
      for (int p = 0; p < NPW; p++) begin
        if (bus_addr_i == A_PRIO + ADDR_W'(p)) prio_q[p*WORD_W +: WORD_W] <= bus_wdata_i;
      end
    end
  end

  assign irq_elig = irq_pend & en_q & ~mask_q;
  assign fiq_elig = fiq_pend & en_q & ~mask_q;

  vic_prio_pick #(.N(NUM_SRC), .PW(PRIO_W), .IW(IDX_W)) u_pick (
    .elig_i  (irq_elig[NUM_SRC-1:0]),
    .prio_i  (prio_q[NUM_SRC*PRIO_W-1:0]),
    .valid_o (pick_valid),
    .idx_o   (pick_idx)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_q <= 1'b0;
      fiq_q <= 1'b0;
      win_q <= IDX_W'(NUM_SRC);
    end else begin
      irq_q <= |irq_elig;
      fiq_q <= |fiq_elig;
      win_q <= pick_valid ? pick_idx : IDX_W'(NUM_SRC);
    end
  end

  assign irq_o  = irq_q;
  assign fiq_o  = fiq_q;
  assign vector = base_q + (WORD_W'(win_q) << 2);

  always_comb begin
    view = '0;
    if (int'(sel_q) < NUM_SRC) begin
      view.en    = en_q[sel_q];
      view.mask  = mask_q[sel_q];
      view.route = route_q[sel_q];
      view.ipnd  = irq_pend[sel_q];
      view.fpnd  = fiq_pend[sel_q];
      view.prio  = prio_q[PRIO_W*int'(sel_q) +: PRIO_W];
    end
  end

  always_comb begin
    bus_rdata_o = '0;
    if (rd_en) begin
      case (bank_e'(bus_addr_i[4:2]))
        BK_CTL: begin
          case (bus_addr_i[1:0])
            2'd0:    bus_rdata_o = vector;
            2'd1:    bus_rdata_o = base_q;
            2'd2:    bus_rdata_o = WORD_W'(sel_q);
            default: bus_rdata_o = WORD_W'(view);
          endcase
        end
        BK_IPND:    bus_rdata_o = ipnd_w[bus_addr_i[1:0]];
        BK_FPND:    bus_rdata_o = fpnd_w[bus_addr_i[1:0]];
        BK_ROUTE:   bus_rdata_o = route_w[bus_addr_i[1:0]];
        BK_EN:      bus_rdata_o = en_w[bus_addr_i[1:0]];
        BK_MASK:    bus_rdata_o = mask_w[bus_addr_i[1:0]];
        BK_PRIO_LO: bus_rdata_o = prio_w[{1'b0, bus_addr_i[1:0]}];
        BK_PRIO_HI: bus_rdata_o = prio_w[{1'b1, bus_addr_i[1:0]}];
        default:    bus_rdata_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/vic_bank_ctrl_chk.sv
module vic_bank_ctrl_chk
  import vic_pkg::*;
#(
  parameter int unsigned NUM_SRC = 96,
  parameter int unsigned PAD     = 96,
  parameter int unsigned IW      = 7
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              irq_o,
  input logic              fiq_o,
  input logic              rd_en,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic [PAD-1:0]    src_pad,
  input logic [PAD-1:0]    route,
  input logic [PAD-1:0]    mask,
  input logic [PAD-1:0]    irq_pend,
  input logic [PAD-1:0]    fiq_pend,
  input logic [PAD-1:0]    irq_elig,
  input logic [IW-1:0]     win_q
);
  localparam int unsigned NW = PAD / WORD_W;

  logic [PAD-1:0] elig_d;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) elig_d <= '0;
    else         elig_d <= irq_elig;
  end

  // R4
  all_masked_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(&mask) |-> (!irq_o && !fiq_o));

  // R8
  vec_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(win_q) <= NUM_SRC);

  // R9
  winner_elig_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int'(win_q) != NUM_SRC) |-> elig_d[win_q]);

  // R11
  sel_write_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en && addr == A_SEL && src_pad == '0) |=> ($stable(irq_pend) && $stable(fiq_pend)));

  for (genvar w = 0; w < NW; w++) begin : g_chk
    // R6
    rd_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rd_en && addr == A_IPND + ADDR_W'(w) &&
       (src_pad[w*WORD_W +: WORD_W] & ~route[w*WORD_W +: WORD_W]) == '0)
      |=> irq_pend[w*WORD_W +: WORD_W] == '0);

    // R7
    rd_collide_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rd_en && addr == A_IPND + ADDR_W'(w) && src_pad[w*WORD_W] && !route[w*WORD_W])
      |=> irq_pend[w*WORD_W]);
  end
endmodule

bind vic_bank_ctrl vic_bank_ctrl_chk #(.NUM_SRC(NUM_SRC), .PAD(PAD), .IW(IDX_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .irq_o    (irq_o),
  .fiq_o    (fiq_o),
  .rd_en    (rd_en),
  .wr_en    (wr_en),
  .addr     (bus_addr_i),
  .src_pad  (src_pad),
  .route    (route_q),
  .mask     (mask_q),
  .irq_pend (irq_pend),
  .fiq_pend (fiq_pend),
  .irq_elig (irq_elig),
  .win_q    (win_q)
);

// File: tb/vic_bank_ctrl_tb_top.sv
`timescale 1ns/1ps
module vic_bank_ctrl_tb_top;
  localparam int N = 40;
  localparam logic [31:0] BASE = 32'h0000_1000;
  localparam logic [31:0] SENT = BASE + 32'(4 * N);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  src = '0;
  logic          req = 1'b0, we = 1'b0;
  logic [4:0]    addr = '0;
  logic [31:0]   wdata = '0;
  logic [31:0]   rdata;
  logic          irq, fiq;
  int            checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  vic_bank_ctrl #(.NUM_SRC(N)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .src_i(src),
    .bus_req_i(req), .bus_we_i(we), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .irq_o(irq), .fiq_o(fiq)
  );

  task automatic step();
    @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %08h exp %08h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b0; addr = a;
    #1 d = rdata;
    @(negedge clk);
    req = 1'b0;
  endtask

  task automatic pulse(input logic [N-1:0] v);
    @(negedge clk);
    src = v;
    @(negedge clk);
    src = '0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d;
    logic [N-1:0] v;
    repeat (3) step();
    rst_n = 1'b1;
    step();

    // R1 reset state
    check("R1 irq_o", 32'(irq), 0);
    check("R1 fiq_o", 32'(fiq), 0);
    rd(5'd20, d); check("R1 mask word0", d, 32'hffff_ffff);
    rd(5'd21, d); check("R1 mask word1", d, 32'hffff_ffff);
    rd(5'd16, d); check("R1 enable word0", d, 0);
    rd(5'd12, d); check("R1 route word0", d, 0);
    rd(5'd24, d); check("R1 prio word0", d, 0);
    rd(5'd1, d);  check("R1 base", d, 0);
    rd(5'd0, d);  check("R1 vector", d, 32'(4 * N));
    rd(5'd6, d);  check("R2 unmapped bank word", d, 0);

    wr(5'd1, BASE);

    // IRQ sweep over every source: R2 R3 R4 R6 R8
    for (int n = 0; n < N; n++) begin
      logic [4:0] k;
      logic [31:0] m;
      k = 5'(n / 32);
      m = 32'd1 << (n % 32);
      wr(5'd16 + k, m);
      wr(5'd20 + k, ~m);
      v = '0; v[n] = 1'b1;
      pulse(v);
      step();
      check($sformatf("R4 irq_o src %0d", n), 32'(irq), 1);
      check($sformatf("R5 fiq_o quiet src %0d", n), 32'(fiq), 0);
      rd(5'd0, d); check($sformatf("R8 vector src %0d", n), d, BASE + 32'(4 * n));
      rd(5'd4 + k, d); check($sformatf("R2 R6 pend word src %0d", n), d, m);
      step();
      check($sformatf("R6 irq_o drop src %0d", n), 32'(irq), 0);
      rd(5'd4 + k, d); check($sformatf("R6 cleared src %0d", n), d, 0);
      rd(5'd0, d); check($sformatf("R8 vector empty src %0d", n), d, SENT);
      wr(5'd16 + k, 32'd0);
      wr(5'd20 + k, 32'hffff_ffff);
    end

    // FIQ sweep: R3 R5
    for (int n = 0; n < N; n++) begin
      logic [4:0] k;
      logic [31:0] m;
      k = 5'(n / 32);
      m = 32'd1 << (n % 32);
      wr(5'd12 + k, m);
      wr(5'd16 + k, m);
      wr(5'd20 + k, ~m);
      v = '0; v[n] = 1'b1;
      pulse(v);
      step();
      check($sformatf("R5 fiq_o src %0d", n), 32'(fiq), 1);
      check($sformatf("R5 irq_o quiet src %0d", n), 32'(irq), 0);
      rd(5'd0, d); check($sformatf("R8 fiq not vectored src %0d", n), d, SENT);
      rd(5'd4 + k, d); check($sformatf("R3 irq pend empty src %0d", n), d, 0);
      rd(5'd8 + k, d); check($sformatf("R3 fiq pend src %0d", n), d, m);
      step();
      check($sformatf("R6 fiq_o drop src %0d", n), 32'(fiq), 0);
      wr(5'd12 + k, 32'd0);
      wr(5'd16 + k, 32'd0);
      wr(5'd20 + k, 32'hffff_ffff);
    end

    // R4 masked source latches but stays quiet, unmask raises it
    wr(5'd16, 32'h20);
    v = '0; v[5] = 1'b1;
    pulse(v); step();
    check("R4 masked quiet", 32'(irq), 0);
    wr(5'd20, 32'hffff_ffdf);
    step();
    check("R4 unmask raises", 32'(irq), 1);
    rd(5'd4, d); check("R3 pend while masked", d, 32'h20);
    wr(5'd16, 32'd0);
    pulse(v); step();
    check("R4 disabled quiet", 32'(irq), 0);
    rd(5'd4, d); check("R3 pend while disabled", d, 32'h20);

    // R6 writes to pending ignored
    wr(5'd4, 32'hffff_ffff);
    rd(5'd4, d); check("R6 pend write ignored", d, 0);

    // R7 request coinciding with clearing read survives
    @(negedge clk); src[7] = 1'b1;
    rd(5'd4, d); check("R7 read during request", d, 32'h80);
    src[7] = 1'b0;
    rd(5'd4, d); check("R7 kept after collision", d, 32'h80);
    rd(5'd4, d); check("R7 cleared afterwards", d, 0);

    // R9 R10 priority ordering
    wr(5'd16, 32'h208);
    wr(5'd17, 32'h8);
    wr(5'd20, 32'd0);
    wr(5'd21, 32'd0);
    v = '0; v[3] = 1'b1; v[9] = 1'b1; v[35] = 1'b1;
    pulse(v); step();
    rd(5'd0, d); check("R9 tie lowest", d, BASE + 32'd12);
    wr(5'd24, 32'h2 << 18); step();
    rd(5'd0, d); check("R9 src9 prio2", d, BASE + 32'd36);
    wr(5'd26, 32'h3 << 6); step();
    rd(5'd0, d); check("R9 R10 src35 prio3", d, BASE + 32'd140);
    wr(5'd24, (32'h2 << 18) | (32'h3 << 6)); step();
    rd(5'd0, d); check("R9 tie at prio3", d, BASE + 32'd12);
    rd(5'd24, d); check("R10 prio readback", d, (32'h2 << 18) | (32'h3 << 6));

    // R11 view and select
    wr(5'd2, 32'd35);
    rd(5'd3, d); check("R11 view src35", d, 32'h69);
    rd(5'd3, d); check("R11 view repeat", d, 32'h69);
    wr(5'd2, 32'd50);
    rd(5'd3, d); check("R11 view out of range", d, 0);
    rd(5'd4, d); check("R11 pend kept word0", d, 32'h208);
    rd(5'd5, d); check("R11 pend kept word1", d, 32'h8);
    step();
    check("R4 all cleared irq_o", 32'(irq), 0);
    rd(5'd0, d); check("R8 empty after clear", d, SENT);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule